// File: doc/BRIEF.md
# Word-Serial Montgomery Multiplier

This block forms the Montgomery product z = x·y·2^-256 mod p of two 256-bit operands under an odd modulus p. The caller pulses `start` together with the multiplicand, the modulus and the word constant p' (with -p·p' ≡ 1 mod 2^32). The multiplier y then arrives as a stream of eight 32-bit words, least significant word first, each marked by `y_valid`. Words may be sent as soon as the cycle after `start`, and they may be spread over time with gaps of any length.

Inside, a product stage forms x·y_i one cycle ahead of a reduction stage. The reduction stage adds that product to the running sum and then removes the low 32 bits by adding a multiple of p. In this way the bus transfer of later words overlaps the reduction of earlier ones. After the eighth reduction, one conditional subtraction brings the sum below p. The result is registered and announced by a one-cycle `done` pulse.

Computing p' and converting operands into or out of the Montgomery domain are left to the caller.

Top module: `mont_word_mul`

## Requirements
- R1: After reset, `done` is 0 and `z` is 0.
- R2: For an odd p below 2^256, with x < p and y < 2^256 delivered as eight 32-bit words, `z` at the `done` pulse equals x·y·2^-256 mod p. Word i of y carries bits [32i+31:32i].
- R3: The result on `z` at a `done` pulse is strictly below p. The internal running sum stays below 2p throughout an operation.
- R4: `done` is high for exactly one cycle. It is high in the cycle that follows the second rising edge after the edge that accepted the eighth word. With words sent back to back from the cycle after `start`, `done` is therefore high after the tenth edge counted from the edge that sampled `start`.
- R5: A cycle with `y_valid` low during an operation leaves the running sum unchanged. It delays `done` by one cycle and does not change the result.
- R6: The block ignores `start` while an operation runs, and x, p and p' are sampled only at an accepted `start`. It also ignores `y_valid` while idle, including in the same cycle as `start`, and ignores any word beyond the eighth of an operation.
- R7: `z` holds its value in every cycle in which `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation; sampled only while idle |
| x_in | input | 256 | Multiplicand, below p |
| p_in | input | 256 | Odd modulus |
| pinv_in | input | 32 | Word constant p' with -p·p' ≡ 1 mod 2^32 |
| y_word | input | 32 | Next word of the multiplier, least significant first |
| y_valid | input | 1 | `y_word` carries a word this cycle |
| z | output | 256 | Montgomery product, held between results |
| done | output | 1 | One-cycle pulse when `z` is updated |

## Verification
The only timed output is the `done` pulse. It is due two edges after the edge that takes the eighth word: one edge for the final reduction and one for the registered correction. That edge is the rising edge right after the bench drives the eighth valid word. The bench therefore records, at that moment, the cycle number at which `done` must be seen, and on every falling edge it compares `done` against that single expected cycle. It checks `z` against the wide-integer reference in that same cycle, and it checks that `z` is unchanged in every other cycle. Stalls, a `start` sent during a run, a word sent alongside `start`, and an extra ninth word all shift or leave that expected cycle in a way the bench model computes on its own.

// File: rtl/mont_pkg.sv
package mont_pkg;

  // Sequencer phases: waiting, streaming/reducing, final correction.
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RUN  = 2'd1,
    PH_FIX  = 2'd2
  } mont_phase_e;

endpackage

// File: rtl/mont_pp_stage.sv
// Product stage: forms x * y_i one cycle ahead of its reduction.
module mont_pp_stage #(
  parameter int OPW = 256,
  parameter int WDW = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take,
  input  logic [OPW-1:0]     x_op,
  input  logic [WDW-1:0]     y_word,
  output logic [OPW+WDW-1:0] t_out,
  output logic               t_vld
);
  localparam int PW = OPW + WDW;

  function automatic logic [PW-1:0] word_product(input logic [OPW-1:0] a,
                                                 input logic [WDW-1:0] b);
    return {{WDW{1'b0}}, a} * {{OPW{1'b0}}, b};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_out <= '0;
      t_vld <= 1'b0;
    end else begin
      t_vld <= take;
      if (take) t_out <= word_product(x_op, y_word);
    end
  end
endmodule

// File: rtl/mont_red_stage.sv
// Reduction step: u = S + t; q = (u mod 2^w) * p' mod 2^w; S' = (q*p + u) >> w.
module mont_red_stage #(
  parameter int OPW = 256,
  parameter int WDW = 32
) (
  input  logic [OPW:0]       acc,
  input  logic [OPW+WDW-1:0] t_in,
  input  logic [OPW-1:0]     p_op,
  input  logic [WDW-1:0]     pinv_op,
  output logic [OPW:0]       acc_next
);
  localparam int UW = OPW + WDW + 2;

  logic [UW-1:0]  u_sum;
  logic [WDW-1:0] q_word;
  logic [UW-1:0]  qp;
  logic [UW-1:0]  total;
  logic           unused_red_bits;

  function automatic logic [WDW-1:0] quotient_digit(input logic [WDW-1:0] low,
                                                    input logic [WDW-1:0] k);
    logic [WDW-1:0] r;
    r = low * k;
    return r;
  endfunction

  always_comb begin
    u_sum  = {{(WDW+1){1'b0}}, acc} + {2'b00, t_in};
    q_word = quotient_digit(u_sum[WDW-1:0], pinv_op);
    qp     = {{(UW-WDW){1'b0}}, q_word} * {{(UW-OPW){1'b0}}, p_op};
    total  = qp + u_sum;
  end

  // Low word of total is zero by choice of q; the top bit is zero because S < 2p.
  assign acc_next        = total[OPW+WDW:WDW];
  assign unused_red_bits = ^{total[UW-1], total[WDW-1:0]};
endmodule

// File: rtl/mont_seq_ctrl.sv
// Sequencer: counts accepted words and completed reductions, steps the phases.
module mont_seq_ctrl
  import mont_pkg::*;
#(
  parameter int NW = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic y_valid,
  input  logic t_vld,
  output logic load_op,
  output logic take,
  output logic fix_now,
  output logic busy
);
  localparam int CW = $clog2(NW + 1);

  mont_phase_e    phase;
  logic [CW-1:0]  word_cnt;
  logic [CW-1:0]  red_cnt;
  logic           last_red;

  assign busy     = (phase != PH_IDLE);
  assign load_op  = start && (phase == PH_IDLE);
  assign take     = (phase == PH_RUN) && y_valid && (word_cnt < CW'(NW));
  assign last_red = (phase == PH_RUN) && t_vld && (red_cnt == CW'(NW - 1));
  assign fix_now  = (phase == PH_FIX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      word_cnt <= '0;
      red_cnt  <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: if (start) begin
          phase    <= PH_RUN;
          word_cnt <= '0;
          red_cnt  <= '0;
        end
        PH_RUN: begin
          if (take)  word_cnt <= word_cnt + 1'b1;
          if (t_vld) red_cnt  <= red_cnt + 1'b1;
          if (last_red) phase <= PH_FIX;
        end
        PH_FIX:  phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mont_word_mul.sv
// Word-serial Montgomery multiplier, top level.
module mont_word_mul #(
  parameter int OPW = 256,
  parameter int WDW = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [OPW-1:0] x_in,
  input  logic [OPW-1:0] p_in,
  input  logic [WDW-1:0] pinv_in,
  input  logic [WDW-1:0] y_word,
  input  logic           y_valid,
  output logic [OPW-1:0] z,
  output logic           done
);
  localparam int NW = OPW / WDW;
  localparam int PW = OPW + WDW;

  logic [OPW-1:0] x_q;
  logic [OPW-1:0] p_q;
  logic [WDW-1:0] pinv_q;
  logic [OPW:0]   acc;
  logic [OPW:0]   acc_next;
  logic [PW-1:0]  t_cur;
  logic           t_vld;
  logic           load_op;
  logic           take;
  logic           fix_now;
  logic           busy;
  logic [OPW-1:0] z_fixed;
  logic           unused_fix_bit;

  // Final correction: one conditional subtraction of p.
  function automatic logic [OPW:0] cond_sub(input logic [OPW:0]   s,
                                            input logic [OPW-1:0] m);
    logic [OPW:0] mm;
    mm = {1'b0, m};
    return (s >= mm) ? (s - mm) : s;
  endfunction

  mont_seq_ctrl #(.NW(NW)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .y_valid (y_valid),
    .t_vld   (t_vld),
    .load_op (load_op),
    .take    (take),
    .fix_now (fix_now),
    .busy    (busy)
  );

  mont_pp_stage #(.OPW(OPW), .WDW(WDW)) u_pp (
    .clk    (clk),
    .rst_n  (rst_n),
    .take   (take),
    .x_op   (x_q),
    .y_word (y_word),
    .t_out  (t_cur),
    .t_vld  (t_vld)
  );

  mont_red_stage #(.OPW(OPW), .WDW(WDW)) u_red (
    .acc      (acc),
    .t_in     (t_cur),
    .p_op     (p_q),
    .pinv_op  (pinv_q),
    .acc_next (acc_next)
  );

  assign {unused_fix_bit, z_fixed} = cond_sub(acc, p_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q    <= '0;
      p_q    <= '0;
      pinv_q <= '0;
      acc    <= '0;
    end else if (load_op) begin
      x_q    <= x_in;
      p_q    <= p_in;
      pinv_q <= pinv_in;
      acc    <= '0;
    end else if (t_vld) begin
      acc    <= acc_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      z    <= '0;
      done <= 1'b0;
    end else begin
      done <= fix_now;
      if (fix_now) z <= z_fixed;
    end
  end
endmodule

// File: rtl/mont_word_mul_chk.sv
// Property checker, attached to every mont_word_mul instance.
module mont_word_mul_chk #(
  parameter int OPW = 256,
  parameter int WDW = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           done,
  input logic [OPW-1:0] z,
  input logic [OPW-1:0] p_q,
  input logic [OPW:0]   acc,
  input logic           busy,
  input logic           t_vld
);
  logic [WDW-1:0] unused_w;
  assign unused_w = '0;

  assert_z_below_p_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (z < p_q));

  assert_acc_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ({1'b0, acc} < {p_q, 1'b0}));

  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));

  assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !t_vld) |=> $stable(acc));

  assert_busy_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(p_q));

  assert_z_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(z));
endmodule

bind mont_word_mul mont_word_mul_chk #(.OPW(OPW), .WDW(WDW)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .start (start),
  .done  (done),
  .z     (z),
  .p_q   (p_q),
  .acc   (acc),
  .busy  (busy),
  .t_vld (t_vld)
);

// File: tb/tb_mont_word_mul.sv
module tb_mont_word_mul;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [255:0] x_in = '0;
  logic [255:0] p_in = '0;
  logic [31:0]  pinv_in = '0;
  logic [31:0]  y_word = '0;
  logic         y_valid = 1'b0;
  logic [255:0] z;
  logic         done;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int exp_done_cyc = -1;
  logic [255:0] exp_z = '0;
  logic [255:0] held_z = '0;
  logic [255:0] cur_p = '0;
  bit finished = 0;

  mont_word_mul dut (
    .clk(clk), .rst_n(rst_n), .start(start), .x_in(x_in), .p_in(p_in),
    .pinv_in(pinv_in), .y_word(y_word), .y_valid(y_valid), .z(z), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Reference: (x*y mod p), then halve modulo p 256 times.
  function automatic logic [255:0] ref_mont(input logic [255:0] a, b, m);
    logic [511:0] prod;
    logic [256:0] r;
    prod = {256'b0, a} * {256'b0, b};
    prod = prod % {256'b0, m};
    r = {1'b0, prod[255:0]};
    for (int k = 0; k < 256; k++) begin
      if (r[0]) r = r + {1'b0, m};
      r = r >> 1;
    end
    return r[255:0];
  endfunction

  // Negated inverse of p modulo 2^32 by Newton iteration.
  function automatic logic [31:0] neg_inv(input logic [31:0] p0);
    logic [31:0] v;
    v = p0;
    for (int k = 0; k < 5; k++) v = v * (32'd2 - p0 * v);
    return -v;
  endfunction

  function automatic logic [255:0] rand256();
    logic [255:0] r;
    for (int k = 0; k < 8; k++) r[32*k +: 32] = $urandom;
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [255:0] act, exp_v);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp_v, cyc);
    end
  endtask

  // Cycle-by-cycle comparison of done and z against the model.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (cyc == exp_done_cyc) begin
        check(done == 1'b1, "R4 done due", {255'b0, done}, 256'd1);
        check(z == exp_z, "R2 product", z, exp_z);
        check(z < cur_p, "R3 below p", z, cur_p);
        held_z = exp_z;
      end else begin
        check(done == 1'b0, "R4 done idle", {255'b0, done}, 256'd0);
        check(z == held_z, "R7 z held", z, held_z);
      end
    end
    if (cyc > WATCHDOG && !finished) begin
      failures++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // gap: idle cycles before each odd word (R5); poke: misuse during run (R6).
  task automatic run_op(input logic [255:0] xa, ya, pa, input int gap, input bit poke);
    @(negedge clk);
    start = 1'b1; x_in = xa; p_in = pa; pinv_in = neg_inv(pa[31:0]);
    exp_z = ref_mont(xa, ya, pa);
    cur_p = pa;
    if (poke) begin y_valid = 1'b1; y_word = 32'hDEAD_BEEF; end   // R6 idle word
    @(negedge clk);
    start = 1'b0; y_valid = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (i % 2 == 1) begin
        for (int g = 0; g < gap; g++) begin
          if (poke && g == 0) begin   // R6 start while busy, inputs changed
            start = 1'b1; x_in = ~xa; p_in = rand256() | 256'd1; pinv_in = ~pinv_in;
          end
          @(negedge clk);
          start = 1'b0;
        end
      end
      y_valid = 1'b1; y_word = ya[32*i +: 32];
      if (i == 7) exp_done_cyc = cyc + 3;
      @(negedge clk);
      y_valid = 1'b0;
    end
    if (poke) begin y_valid = 1'b1; y_word = 32'h1234_5678; end   // R6 ninth word
    while (cyc <= exp_done_cyc) begin
      @(negedge clk);
      y_valid = 1'b0;
    end
  endtask

  logic [255:0] pr, xr, yr;

  initial begin
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R1 reset done", {255'b0, done}, 256'd0);
    check(z == '0, "R1 reset z", z, 256'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(z == '0 && done == 1'b0, "R1 after release", z, 256'd0);

    // R2/R4 corners, back to back words
    run_op(256'd1, 256'd1, 256'd13, 0, 0);
    run_op(256'd0, rand256(), 256'd1000000007, 0, 0);
    pr = {256{1'b1}};
    run_op(pr - 1, pr - 1, pr, 0, 0);
    run_op(pr - 5, {256{1'b1}}, pr, 0, 0);
    pr = {1'b1, 254'b0, 1'b1};
    run_op(pr - 1, 256'd0, pr, 0, 0);
    // R5 stalls
    pr = rand256() | 256'd1; pr[255] = 1'b1;
    run_op(rand256() % pr, rand256() % pr, pr, 1, 0);
    run_op(rand256() % pr, rand256() % pr, pr, 4, 0);
    // R6 misuse
    run_op(rand256() % pr, rand256() % pr, pr, 2, 1);
    // random R2 sweep
    for (int k = 0; k < 20; k++) begin
      pr = rand256() | 256'd1;
      xr = rand256() % pr;
      yr = rand256() % pr;
      run_op(xr, yr, pr, k % 3, (k % 5) == 0);
    end
    repeat (3) @(negedge clk);
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule